// File: doc/BRIEF.md
# Framing Unit Byte FIFO Bus Bridge

This block is the processor-facing side of a contactless framing unit. It links the unit's byte-stream control logic with a 16-bit memory-mapped processor bus through one small byte FIFO. The FIFO carries traffic in one direction at a time. In receive mode the control logic pushes incoming application bytes and the processor pops them by reading the data register. In transmit mode the processor writes response bytes and the control logic drains them for sending.

A configuration register holds the direction bit and seven framing-parameter bits, which are passed straight to the framing logic. A status register reports FIFO state and a sticky overflow flag. The fill count is also driven on dedicated sideband wires, so the processor can poll it without spending a bus cycle. Only the low byte of the bus carries data.

Top module: `fl_bus_bridge`

## Requirements
- R1: After a synchronous active-low reset, `fill_count` is 0, the configuration register reads 0 (receive direction), and the status register reads 0x0001.
- R2: In receive direction (config bit 0 = 0), `cu_rx_valid` pushes `cu_rx_byte`. A bus read at offset 0 returns the oldest byte in bits 7:0 in the same cycle and pops it. Bits 15:8 of every bus read are zero.
- R3: In transmit direction (config bit 0 = 1), a bus write at offset 0 pushes `bus_wdata[7:0]`. `cu_tx_avail` is 1 while the FIFO is non-empty, `cu_tx_byte` shows the oldest byte, and `cu_tx_pop` removes that byte.
- R4: Accesses from the side that does not own the current direction have no effect. In receive direction, a bus write at offset 0 and `cu_tx_pop` are ignored. In transmit direction, `cu_rx_valid` is ignored, and a bus read at offset 0 returns 0 and pops nothing.
- R5: The FIFO holds at most 6 bytes. A push into a full FIFO with no pop in the same cycle is dropped and sets the overflow flag (status bit 2).
- R6: The overflow flag stays set until a status write with bit 2 = 1. A status write with bit 2 = 0 leaves it unchanged. If a dropped push and a clearing write fall in the same cycle, the flag ends set.
- R7: A push and a pop on a full FIFO in the same cycle are both accepted. The count stays 6 and no overflow is flagged.
- R8: A configuration write that changes bit 0 empties the FIFO, and a push offered in that cycle is discarded without flagging overflow. A configuration write that keeps bit 0 does not touch the FIFO.
- R9: The status byte holds empty in bit 0, full in bit 1, overflow in bit 2, direction in bit 3 and the fill count in bits 6:4. `fill_count` always equals the number of stored bytes.
- R10: A pop from an empty FIFO is ignored: the count stays 0 and a data read returns 0.
- R11: Offset 2 reads back the last written configuration byte (bits 15:8 of the write are dropped). `frame_cfg` shows configuration bits 7:1. Offset 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 data, 1 status, 2 config |
| bus_wdata | input | 16 | Write data, low byte used |
| bus_rdata | output | 16 | Read data, upper byte zero |
| cu_rx_valid | input | 1 | Control logic offers a received byte |
| cu_rx_byte | input | 8 | Received byte |
| cu_tx_pop | input | 1 | Control logic takes the head byte |
| cu_tx_byte | output | 8 | Head byte in transmit direction |
| cu_tx_avail | output | 1 | Transmit byte available |
| fill_count | output | 3 | Bytes stored in the FIFO |
| frame_cfg | output | 7 | Framing parameter bits (config 7:1) |

## Verification
The critical overlap is a push and a pop in the same cycle while the FIFO is full. Both must be accepted, with no overflow. A related case is a dropped push that lands in the same cycle as a write-one-to-clear of the overflow flag, where the set must win. Both overlaps are forced by directed steps that fill the FIFO to six bytes. Random traffic that drives both sides every cycle then revisits them many times. A bench model tracks the queue, flag and configuration, and checks each read value, the head byte and the sideband count against it cycle by cycle.

// File: rtl/fl_bridge_pkg.sv
// Package: shared register offsets, status bit positions and direction codes
// for the framing-unit bus bridge. Assumes a byte-wide status register.
package fl_bridge_pkg;
    typedef enum logic [1:0] {
        REG_DATA   = 2'd0,
        REG_STATUS = 2'd1,
        REG_CONFIG = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;

    localparam int ST_EMPTY = 0;
    localparam int ST_FULL  = 1;
    localparam int ST_OVF   = 2;
    localparam int ST_DIR   = 3;
    localparam int ST_CNT   = 4;

    localparam logic DIR_RX = 1'b0;
    localparam logic DIR_TX = 1'b1;
endpackage

// File: rtl/fl_byte_fifo.sv
// Module: circular byte FIFO of any depth (not only powers of two).
// A pop and a push in the same cycle are both taken even when full.
// A flush overrides both. Assumes the caller gates push/pop by direction.
module fl_byte_fifo #(
    parameter int DEPTH  = 6,
    parameter int BYTE_W = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop,
    output logic [BYTE_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              drop
);
    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Acceptance: pop needs data, push needs room or a same-cycle pop.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        pop_ok  = pop && !flush && !empty;
        push_ok = push && !flush && (!full || pop_ok);
        drop    = push && !flush && full && !pop_ok;
        head    = mem[rd_ptr];
    end

    // Per-entry storage write, one enable per slot.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PTR_W'(i))
                mem[i] <= push_data;
        end
    end

    // Pointer and count update with flush taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)); // R5
    AST_FULL_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> full); // R5
    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty); // R8
    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> empty); // R10
endmodule

// File: rtl/fl_bus_regs.sv
// Module: bus register decode for the bridge. Holds the configuration
// byte and the sticky overflow flag. Builds read data and derives the
// data-port push/pop strobes by direction. Reads are combinational.
// Assumes ST_CNT + CNT_W <= BYTE_W.
module fl_bus_regs
    import fl_bridge_pkg::*;
#(
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [BYTE_W-1:0] fifo_head,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_empty,
    input  logic              fifo_full,
    input  logic              fifo_drop,
    output logic [BYTE_W-1:0] cfg_q,
    output logic              flush,
    output logic              data_push,
    output logic              data_pop
);
    logic              ovf_q;
    logic              dir;
    logic              wr_stat, wr_cfg, ovf_clr;
    logic [BYTE_W-1:0] status_b, rd_byte;

    // Access decode and direction-gated data strobes.
    always_comb begin
        dir       = cfg_q[0];
        wr_stat   = bus_sel && bus_wr && (bus_addr == REG_STATUS);
        wr_cfg    = bus_sel && bus_wr && (bus_addr == REG_CONFIG);
        ovf_clr   = wr_stat && bus_wdata[ST_OVF];
        flush     = wr_cfg && (bus_wdata[0] != dir);
        data_push = bus_sel && bus_wr && (bus_addr == REG_DATA) && (dir == DIR_TX);
        data_pop  = bus_sel && !bus_wr && (bus_addr == REG_DATA) && (dir == DIR_RX);
    end

    // Status byte assembly and read multiplexer.
    always_comb begin
        status_b                  = '0;
        status_b[ST_EMPTY]        = fifo_empty;
        status_b[ST_FULL]         = fifo_full;
        status_b[ST_OVF]          = ovf_q;
        status_b[ST_DIR]          = dir;
        status_b[ST_CNT +: CNT_W] = fifo_count;
        case (bus_addr)
            REG_DATA:   rd_byte = data_pop && !fifo_empty ? fifo_head : '0;
            REG_STATUS: rd_byte = status_b;
            REG_CONFIG: rd_byte = cfg_q;
            default:    rd_byte = '0;
        endcase
        bus_rdata              = '0;
        bus_rdata[BYTE_W-1:0]  = (bus_sel && !bus_wr) ? rd_byte : '0;
    end

    // Configuration register: low byte of any config write.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (wr_cfg) cfg_q <= bus_wdata[BYTE_W-1:0];
    end

    // Sticky overflow: a drop sets it and wins over a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n)         ovf_q <= 1'b0;
        else if (fifo_drop) ovf_q <= 1'b1;
        else if (ovf_clr)   ovf_q <= 1'b0;
    end

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q); // R6
    AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_drop |=> ovf_q); // R5
endmodule

// File: rtl/fl_bus_bridge.sv
// Module: top of the framing-unit bus bridge. Routes push/pop between the
// control-logic port and the bus port according to the direction bit.
// Exports the fill count and framing parameter bits as sideband.
// Assumes one bus access per cycle.
module fl_bus_bridge
    import fl_bridge_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int BUS_W  = 16,
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic              cu_rx_valid,
    input  logic [BYTE_W-1:0] cu_rx_byte,
    input  logic              cu_tx_pop,
    output logic [BYTE_W-1:0] cu_tx_byte,
    output logic              cu_tx_avail,
    output logic [CNT_W-1:0]  fill_count,
    output logic [BYTE_W-2:0] frame_cfg
);
    logic [BYTE_W-1:0] cfg_q, head, push_data;
    logic              flush, data_push, data_pop;
    logic              f_push, f_pop, f_empty, f_full, f_drop;
    logic              tx_mode;

    // Direction steering of the single shared FIFO.
    always_comb begin
        tx_mode     = (cfg_q[0] == DIR_TX);
        f_push      = tx_mode ? data_push : cu_rx_valid;
        push_data   = tx_mode ? bus_wdata[BYTE_W-1:0] : cu_rx_byte;
        f_pop       = tx_mode ? cu_tx_pop : data_pop;
        cu_tx_avail = tx_mode && !f_empty;
        cu_tx_byte  = cu_tx_avail ? head : '0;
        frame_cfg   = cfg_q[BYTE_W-1:1];
    end

    fl_bus_regs #(.BUS_W(BUS_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .fifo_head  (head),
        .fifo_count (fill_count),
        .fifo_empty (f_empty),
        .fifo_full  (f_full),
        .fifo_drop  (f_drop),
        .cfg_q      (cfg_q),
        .flush      (flush),
        .data_push  (data_push),
        .data_pop   (data_pop)
    );

    fl_byte_fifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (f_push),
        .push_data (push_data),
        .pop       (f_pop),
        .head      (head),
        .count     (fill_count),
        .empty     (f_empty),
        .full      (f_full),
        .drop      (f_drop)
    );

    AST_TX_SIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_mode && !cu_rx_valid && !flush && $stable(cfg_q)) |=> (fill_count <= $past(fill_count))); // R4
endmodule

// File: tb/tb_fl_bus_bridge.sv
`timescale 1ns/1ps
module tb_fl_bus_bridge;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [1:0]  bus_addr;
    logic [15:0] bus_wdata, bus_rdata;
    logic        cu_rx_valid, cu_tx_pop, cu_tx_avail;
    logic [7:0]  cu_rx_byte, cu_tx_byte;
    logic [2:0]  fill_count;
    logic [6:0]  frame_cfg;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    logic [7:0] q[$];
    bit         m_ovf;
    logic [7:0] m_cfg;

    always #2.5 clk = ~clk;

    fl_bus_bridge dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cu_rx_valid(cu_rx_valid), .cu_rx_byte(cu_rx_byte), .cu_tx_pop(cu_tx_pop),
        .cu_tx_byte(cu_tx_byte), .cu_tx_avail(cu_tx_avail),
        .fill_count(fill_count), .frame_cfg(frame_cfg)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_rdata(input logic [1:0] addr);
        logic [7:0] b;
        b = 8'h00;
        case (addr)
            2'd0: b = (!m_cfg[0] && q.size() > 0) ? q[0] : 8'h00;
            2'd1: b = {1'b0, 3'(q.size()), m_cfg[0], m_ovf, q.size() == 6, q.size() == 0};
            2'd2: b = m_cfg;
            default: b = 8'h00;
        endcase
        return {8'h00, b};
    endfunction

    // One clock of stimulus: drive, check pre-edge outputs, advance the model.
    task automatic step(input logic rv, input logic [7:0] rb, input logic tp,
                        input logic sel, input logic wr, input logic [1:0] addr,
                        input logic [15:0] wd, input string tag);
        bit flush, push_req, pop_req, pop_ok, push_ok;
        logic [7:0] pd;
        @(negedge clk);
        cu_rx_valid = rv; cu_rx_byte = rb; cu_tx_pop = tp;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        #0.5;
        check(fill_count == 3'(q.size()), tag, "fill_count", fill_count, q.size());
        check(frame_cfg == m_cfg[7:1], tag, "frame_cfg", frame_cfg, m_cfg[7:1]);
        check(cu_tx_avail == (m_cfg[0] && q.size() > 0), tag, "cu_tx_avail",
              cu_tx_avail, (m_cfg[0] && q.size() > 0));
        if (m_cfg[0] && q.size() > 0)
            check(cu_tx_byte == q[0], tag, "cu_tx_byte", cu_tx_byte, q[0]);
        if (sel && !wr)
            check(bus_rdata == exp_rdata(addr), tag, "bus_rdata", bus_rdata, exp_rdata(addr));
        flush = sel && wr && addr == 2'd2 && wd[0] != m_cfg[0];
        if (flush) begin
            q.delete();
            m_cfg = wd[7:0];
        end else begin
            push_req = m_cfg[0] ? (sel && wr && addr == 2'd0) : rv;
            pd       = m_cfg[0] ? wd[7:0] : rb;
            pop_req  = m_cfg[0] ? tp : (sel && !wr && addr == 2'd0);
            pop_ok   = pop_req && q.size() > 0;
            push_ok  = push_req && (q.size() < 6 || pop_ok);
            if (sel && wr && addr == 2'd1 && wd[2]) m_ovf = 0;
            if (push_req && !push_ok) m_ovf = 1;
            if (pop_ok) void'(q.pop_front());
            if (push_ok) q.push_back(pd);
            if (sel && wr && addr == 2'd2) m_cfg = wd[7:0];
        end
        @(posedge clk);
    endtask

    task automatic idle(input string tag);
        step(0, 8'h00, 0, 0, 0, 2'd0, 16'h0000, tag);
    endtask

    task automatic rd(input logic [1:0] a, input string tag);
        step(0, 8'h00, 0, 1, 0, a, 16'h0000, tag);
    endtask

    task automatic wrr(input logic [1:0] a, input logic [15:0] d, input string tag);
        step(0, 8'h00, 0, 1, 1, a, d, tag);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; cu_rx_valid = 0; cu_rx_byte = 0; cu_tx_pop = 0;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        q.delete(); m_ovf = 0; m_cfg = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        rd(2'd1, "R1 status");
        rd(2'd2, "R1 config");
        // R10: pop from empty
        rd(2'd0, "R10 empty read");
        idle("R10 count hold");
        // R2: receive path, upper byte zero
        step(1, 8'hA1, 0, 0, 0, 2'd0, 16'h0, "R2 push");
        step(1, 8'hB2, 0, 0, 0, 2'd0, 16'h0, "R2 push");
        step(1, 8'hC3, 0, 0, 0, 2'd0, 16'h0, "R2 push");
        rd(2'd0, "R2 read");
        // R4: wrong-side access in receive direction
        wrr(2'd0, 16'hFF55, "R4 bus write ignored");
        step(0, 8'h00, 1, 0, 0, 2'd0, 16'h0, "R4 tx_pop ignored");
        rd(2'd0, "R2 read");
        rd(2'd0, "R2 read");
        // R5: fill to 6, then overflow
        for (int i = 0; i < 7; i++)
            step(1, 8'(8'h10 + i), 0, 0, 0, 2'd0, 16'h0, "R5 fill");
        rd(2'd1, "R9 status full+ovf");
        // R6: write 0 keeps, write 1 clears
        wrr(2'd1, 16'h00FB, "R6 write zero");
        rd(2'd1, "R6 still set");
        wrr(2'd1, 16'h0004, "R6 clear");
        rd(2'd1, "R6 cleared");
        // R7: push and pop together on full
        step(1, 8'h77, 0, 1, 0, 2'd0, 16'h0, "R7 push+pop full");
        rd(2'd1, "R7 no overflow");
        // R6: drop and clear in the same cycle, set wins
        step(1, 8'h88, 0, 1, 1, 2'd1, 16'h0004, "R6 set wins");
        rd(2'd1, "R6 set wins status");
        wrr(2'd1, 16'h0004, "R6 clear");
        // R8: same-dir config write keeps data, change flushes
        wrr(2'd2, 16'h00A0, "R8 same dir");
        rd(2'd1, "R8 kept");
        step(1, 8'h99, 0, 1, 1, 2'd2, 16'h0001, "R8 flush with push");
        rd(2'd1, "R8 flushed");
        // R3: transmit path
        wrr(2'd0, 16'h1234, "R3 push");
        wrr(2'd0, 16'h0056, "R3 push");
        step(1, 8'hEE, 0, 0, 0, 2'd0, 16'h0, "R4 cu_rx ignored");
        rd(2'd0, "R4 tx read zero");
        step(0, 8'h00, 1, 0, 0, 2'd0, 16'h0, "R3 pop");
        step(0, 8'h00, 1, 0, 0, 2'd0, 16'h0, "R3 pop");
        step(0, 8'h00, 1, 0, 0, 2'd0, 16'h0, "R10 tx empty pop");
        // R11: config readback, unmapped offset
        wrr(2'd2, 16'hBEFF, "R11 write");
        rd(2'd2, "R11 readback");
        wrr(2'd3, 16'hFFFF, "R11 unmapped write");
        rd(2'd3, "R11 unmapped read");
        rd(2'd2, "R11 readback");

        // Random traffic mixing both sides (R2 R3 R5 R7 R9)
        for (int n = 0; n < 6000; n++) begin
            logic [3:0]  k;
            logic [1:0]  a;
            logic [15:0] d;
            logic        s, w;
            k = 4'($urandom_range(0, 15));
            d = 16'($urandom);
            s = 1; w = 0; a = 2'd0;
            case (k)
                0, 1, 2, 3: begin s = 1; w = 0; a = 2'd0; end
                4, 5, 6:    begin s = 1; w = 1; a = 2'd0; end
                7:          begin s = 1; w = 0; a = 2'd1; end
                8:          begin s = 1; w = 1; a = 2'd1; end
                9:          begin s = 1; w = 0; a = 2'($urandom_range(2, 3)); end
                10:         begin s = 1; w = 1; a = 2'd2;
                                  if ($urandom_range(0, 7) != 0) d[0] = m_cfg[0]; end
                default:    s = 0;
            endcase
            step(1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 1)),
                 s, w, a, d, "R9 random");
        end
        idle("R9 final");

        done = 1;
        summary();
        $finish;
    end
endmodule